// File: doc/BRIEF.md
# Timestamp Record Queue with Word-Serial Host Readout

This block holds timestamp records for packets that carry precision-time event messages. It serves one port and one direction. A capture engine presents a complete record in one cycle. The record holds a message tag, seconds, nanoseconds, clock identity, source port number and sequence id. The block queues the record if capture is enabled and there is room. If the queue is full it drops the record and counts the loss.

The host reads each record through one 16-bit data port, one word per read strobe. The block splits the 192-bit record into twelve words and presents each multi-word field with its most significant word first. The host rebuilds each value by shifting left 16 bits and OR-ing in the next word. A status word reports three things:
- a read-position index that shows where the host is within the current record,
- the capture enable,
- a saturating count of discarded events.

A not-empty flag tells the host that a record is waiting.

Top module: `ts_record_queue`

## Requirements
- R1: After a synchronous reset, `not_empty` is 0, `host_status` is 0 and `host_data` is 0.
- R2: A record is read as 12 words in this order: tag (1), seconds (3), nanoseconds (2), clock identity (4), port number (1), sequence id (1). Within each multi-word field the most significant word comes first.
- R3: The status bits 12:8 hold the read position. It is 0 when the next read returns a tag word, rises by 1 on each read of a non-empty queue, and returns to 0 after the 12th word, which removes the record.
- R4: Status bit 15 is the capture enable. A status write loads it from `stat_wr_enable`. While it is 0, capture pushes are ignored: they are neither stored nor counted.
- R5: Status bits 7:4 count pushes that were lost because the queue was full while capture was enabled. The count saturates at 15.
- R6: A status write clears the discard count.
- R7: A read strobe while the queue is empty returns 0 on `host_data` and leaves the read position unchanged.
- R8: Records leave in the order they were pushed, and the queue holds DEPTH records (default 8).
- R9: If a push and the pop caused by reading the 12th word arrive in the same cycle on a full queue, both take effect and nothing is counted as discarded.
- R10: `not_empty` rises in the cycle after an accepted push into an empty queue. It falls after the last word of the last record has been read.
- R11: Status bits 14:13 and 3:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Capture engine presents a record this cycle |
| cap_tag | input | 16 | Message tag |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Source clock identity |
| cap_port | input | 16 | Source port number |
| cap_seq | input | 16 | Sequence id |
| host_rd | input | 1 | Data-register read strobe, one word per cycle |
| stat_wr | input | 1 | Status-register write strobe |
| stat_wr_enable | input | 1 | Value written to the enable bit |
| host_data | output | 16 | Current word (combinational), 0 when empty |
| host_status | output | 16 | Enable, read position and discard count |
| not_empty | output | 1 | At least one record is queued |

## Verification
The data word and the read position are valid in the cycle the strobe is asserted. The bench therefore compares `host_data` a moment after it raises `host_rd`, before the clock edge. The position, the pop, the not-empty flag, the enable and the discard count change at the edge that takes the strobe or push. They are visible one cycle later, and the bench checks them at the following falling edge. The case where a push and a 12th-word read share one edge is driven within a single cycle. It is then judged by whether the discard count stays 0 and by the order in which records come out afterwards.

// File: rtl/ts_queue_pkg.sv
package ts_queue_pkg;
    localparam int WORD_W   = 16;
    localparam int TAG_W    = 16;
    localparam int SEC_W    = 48;
    localparam int NSEC_W   = 32;
    localparam int CLKID_W  = 64;
    localparam int PORTN_W  = 16;
    localparam int SEQ_W    = 16;
    localparam int REC_W    = TAG_W + SEC_W + NSEC_W + CLKID_W + PORTN_W + SEQ_W;
    localparam int REC_WORDS = REC_W / WORD_W;
    localparam int POS_W    = 5;
    localparam int DISC_W   = 4;

    // First member is most significant: the host reads from the top down.
    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [SEC_W-1:0]   sec;
        logic [NSEC_W-1:0]  nsec;
        logic [CLKID_W-1:0] clkid;
        logic [PORTN_W-1:0] portn;
        logic [SEQ_W-1:0]   seq;
    } ts_rec_t;

    typedef struct packed {
        logic              enable;
        logic [1:0]        rsvd_hi;
        logic [POS_W-1:0]  pos;
        logic [DISC_W-1:0] disc;
        logic [3:0]        rsvd_lo;
    } ts_status_t;

    function automatic logic [WORD_W-1:0] word_at(ts_rec_t r, logic [POS_W-1:0] k);
        logic [REC_W-1:0] flat;
        flat = r;
        flat = flat << (WORD_W * int'(k));
        return flat[REC_W-1 -: WORD_W];
    endfunction
endpackage

// File: rtl/ts_rec_store.sv
module ts_rec_store
    import ts_queue_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  logic    pop,
    input  ts_rec_t din,
    output ts_rec_t head,
    output logic    empty,
    output logic    full,
    output logic    dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    ts_rec_t         mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            wr_en, rd_en;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign rd_en   = pop && !empty;
    assign wr_en   = push && (!full || rd_en);
    assign dropped = push && full && !rd_en;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    a_r9_full_swap: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full) |=> full);
endmodule

// File: rtl/ts_word_reader.sv
module ts_word_reader
    import ts_queue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              empty,
    input  ts_rec_t           head,
    output logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] word,
    output logic              pop
);
    localparam logic [POS_W-1:0] LAST = POS_W'(REC_WORDS - 1);

    assign pop  = strobe && !empty && (pos == LAST);
    assign word = empty ? '0 : word_at(head, pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (strobe && !empty) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    a_r3_pos_bound: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (strobe && !empty && pos == LAST) |=> pos == '0);
    a_r7_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (strobe && empty) |=> $stable(pos));
endmodule

// File: rtl/ts_status_reg.sv
module ts_status_reg
    import ts_queue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              wr_enable,
    input  logic              dropped,
    output logic              enable,
    output logic [DISC_W-1:0] disc
);
    localparam logic [DISC_W-1:0] DMAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            disc   <= '0;
        end else if (wr) begin
            enable <= wr_enable;
            disc   <= '0;
        end else if (dropped && disc != DMAX) begin
            disc <= disc + 1'b1;
        end
    end

    a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
        (disc == DMAX && !wr) |=> disc == DMAX);
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        wr |=> disc == '0);
endmodule

// File: rtl/ts_record_queue.sv
module ts_record_queue
    import ts_queue_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_valid,
    input  logic [15:0]  cap_tag,
    input  logic [47:0]  cap_sec,
    input  logic [31:0]  cap_nsec,
    input  logic [63:0]  cap_clkid,
    input  logic [15:0]  cap_port,
    input  logic [15:0]  cap_seq,
    input  logic         host_rd,
    input  logic         stat_wr,
    input  logic         stat_wr_enable,
    output logic [15:0]  host_data,
    output logic [15:0]  host_status,
    output logic         not_empty
);
    ts_rec_t           cap_rec, head;
    ts_status_t        stat;
    logic              empty, full, dropped, pop, enable, push;
    logic [POS_W-1:0]  pos;
    logic [DISC_W-1:0] disc;

    assign cap_rec = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec,
                       clkid: cap_clkid, portn: cap_port, seq: cap_seq};
    assign push    = cap_valid && enable;

    ts_rec_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .din(cap_rec),
        .head(head), .empty(empty), .full(full), .dropped(dropped)
    );

    ts_word_reader u_reader (
        .clk(clk), .rst(rst), .strobe(host_rd), .empty(empty), .head(head),
        .pos(pos), .word(host_data), .pop(pop)
    );

    ts_status_reg u_status (
        .clk(clk), .rst(rst), .wr(stat_wr), .wr_enable(stat_wr_enable),
        .dropped(dropped), .enable(enable), .disc(disc)
    );

    assign stat = '{enable: enable, rsvd_hi: 2'b00, pos: pos, disc: disc, rsvd_lo: 4'h0};
    assign host_status = stat;
    assign not_empty   = !empty;

    a_r4_gate: assert property (@(posedge clk) disable iff (rst)
        (!enable && !pop && empty) |=> empty);
    a_r10_flag_low: assert property (@(posedge clk) disable iff (rst)
        (!cap_valid && empty) |=> empty);
endmodule

// File: tb/sim_ts_record_queue.sv
module sim_ts_record_queue;
    logic        clk = 1'b0;
    logic        rst;
    logic        cap_valid;
    logic [15:0] cap_tag, cap_port, cap_seq;
    logic [47:0] cap_sec;
    logic [31:0] cap_nsec;
    logic [63:0] cap_clkid;
    logic        host_rd, stat_wr, stat_wr_enable;
    logic [15:0] host_data, host_status;
    logic        not_empty;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ts_record_queue #(.DEPTH(8)) u0 (.*);

    function automatic logic [15:0] exp_word(int id, int k);
        logic [47:0] s = {16'h5A00 + 16'(id), 32'h1000_0000 + 32'(id)};
        logic [31:0] n = 32'h3B9A_0000 + 32'(id * 3);
        logic [63:0] c = {32'hC0DE_0000 + 32'(id), 32'h0BAD_F00D ^ 32'(id)};
        case (k)
            0:  return 16'h0100 + 16'(id);
            1:  return s[47:32];
            2:  return s[31:16];
            3:  return s[15:0];
            4:  return n[31:16];
            5:  return n[15:0];
            6:  return c[63:48];
            7:  return c[47:32];
            8:  return c[31:16];
            9:  return c[15:0];
            10: return 16'h0200 + 16'(id);
            default: return 16'h7000 + 16'(id);
        endcase
    endfunction

    function automatic logic [15:0] st(logic en, int pos, int disc);
        return {en, 2'b00, 5'(pos), 4'(disc), 4'h0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_rec(int id);
        logic [15:0] w [12];
        for (int k = 0; k < 12; k++) w[k] = exp_word(id, k);
        cap_valid = 1'b1;
        cap_tag   = w[0];
        cap_sec   = {w[1], w[2], w[3]};
        cap_nsec  = {w[4], w[5]};
        cap_clkid = {w[6], w[7], w[8], w[9]};
        cap_port  = w[10];
        cap_seq   = w[11];
    endtask

    task automatic push_rec(int id);
        drive_rec(id);
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic write_status(logic en);
        stat_wr = 1'b1;
        stat_wr_enable = en;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    // Reads all 12 words of record id, checking word and position (R2, R3).
    task automatic read_record(int id, logic en, int disc);
        for (int k = 0; k < 12; k++) begin
            host_rd = 1'b1;
            #1;
            chk("R2 word", {16'h0, host_data}, {16'h0, exp_word(id, k)});
            chk("R3 pos", {16'h0, host_status}, {16'h0, st(en, k, disc)});
            @(negedge clk);
            host_rd = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R1 not_empty", {31'h0, not_empty}, 32'h0);
        chk("R1 status", {16'h0, host_status}, 32'h0);
        chk("R1 data", {16'h0, host_data}, 32'h0);
    endtask

    task automatic t_disabled;
        push_rec(99);
        @(negedge clk);
        chk("R4 ignored when disabled", {31'h0, not_empty}, 32'h0);
        chk("R4 no count when disabled", {16'h0, host_status}, 32'h0);
    endtask

    task automatic t_single;
        write_status(1'b1);
        chk("R4 enable set", {16'h0, host_status}, {16'h0, st(1, 0, 0)});
        push_rec(1);
        chk("R10 rise", {31'h0, not_empty}, 32'h1);
        read_record(1, 1, 0);
        chk("R10 fall", {31'h0, not_empty}, 32'h0);
        chk("R3 wrap", {16'h0, host_status}, {16'h0, st(1, 0, 0)});
    endtask

    task automatic t_empty_read;
        host_rd = 1'b1;
        #1;
        chk("R7 zero data", {16'h0, host_data}, 32'h0);
        @(negedge clk);
        host_rd = 1'b0;
        chk("R7 pos held", {16'h0, host_status}, {16'h0, st(1, 0, 0)});
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 8; i++) push_rec(20 + i);
        chk("R8 full no drop", {16'h0, host_status}, {16'h0, st(1, 0, 0)});
        push_rec(90);
        push_rec(91);
        chk("R5 count 2", {16'h0, host_status}, {16'h0, st(1, 0, 2)});
        for (int i = 0; i < 20; i++) push_rec(92);
        chk("R5 saturate", {16'h0, host_status}, {16'h0, st(1, 0, 15)});
        write_status(1'b1);
        chk("R6 clear", {16'h0, host_status}, {16'h0, st(1, 0, 0)});
        chk("R11 reserved", {16'h0, host_status & 16'h600F}, 32'h0);
        for (int i = 0; i < 8; i++) read_record(20 + i, 1, 0);
        chk("R8 drained", {31'h0, not_empty}, 32'h0);
    endtask

    task automatic t_swap;
        for (int i = 0; i < 8; i++) push_rec(40 + i);
        for (int k = 0; k < 11; k++) begin
            host_rd = 1'b1;
            @(negedge clk);
        end
        drive_rec(48);
        #1;
        chk("R9 last word", {16'h0, host_data}, {16'h0, exp_word(40, 11)});
        @(negedge clk);
        host_rd = 1'b0;
        cap_valid = 1'b0;
        chk("R9 no discard", {16'h0, host_status}, {16'h0, st(1, 0, 0)});
        for (int i = 1; i <= 8; i++) read_record(40 + i, 1, 0);
        chk("R9 drained", {31'h0, not_empty}, 32'h0);
    endtask

    task automatic t_disable_again;
        write_status(1'b0);
        push_rec(60);
        push_rec(61);
        @(negedge clk);
        chk("R4 disabled push", {31'h0, not_empty}, 32'h0);
        chk("R4 disabled status", {16'h0, host_status}, {16'h0, st(0, 0, 0)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cap_valid = 1'b0; host_rd = 1'b0;
        stat_wr = 1'b0; stat_wr_enable = 1'b0;
        cap_tag = '0; cap_sec = '0; cap_nsec = '0;
        cap_clkid = '0; cap_port = '0; cap_seq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_single();
        t_empty_read();
        t_overflow();
        t_swap();
        t_disable_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule